// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Selector

This block decides, cycle by cycle, whether an in-order five-stage pipeline with extra multicycle execute lanes may advance. It looks at the two source registers of the instruction in execute and at the data register of a store in the memory stage. Each of these is compared with the older instructions still in flight. The outcome for each operand is one of three: take a bypassed result from a named older slot, read the register file, or hold the pipeline until the producer is ready.

The surrounding pipeline presents the older in-flight instructions as an ordered list of slots. Slot 0 is the nearest, meaning the youngest of the older ones. Each slot carries a valid bit, a destination register and a ready flag. A slot is marked ready once its producer has reached memory or writeback, or once its multicycle unit has produced the value. A per-register pending-write scoreboard, set at issue and cleared by the last writer at writeback, gates every comparison. Writeback collisions are caught at writeback itself, and stalls ripple from an older stage to every younger one. The block is purely combinational; the operand muxes and the register file sit outside it.

Top module: `hazard_unit`

## Requirements
- R1: A source or store-data register numbered 0 never causes a stall and always selects code 0 (register file).
- R2: An operand whose scoreboard bit is clear never stalls and selects code 0, whatever the slots hold.
- R3: Slots are searched from index 0 upward, skipping invalid slots, and only the lowest-index slot whose destination equals the operand decides the outcome.
- R4: If the deciding slot is ready, the operand's select output equals that slot index plus 1 and no stall is raised for it.
- R5: If the deciding slot is not ready, the select output is 0 and the execute stage stalls.
- R6: A pending operand with no matching valid slot selects code 0 (register file) and raises no stall.
- R7: When the memory stage holds a valid store, its data register is searched only among slots flagged as older than the store; a not-ready match stalls the memory stage, a ready match drives the store select.
- R8: The writeback stage stalls when it holds a valid instruction with a non-zero destination and any valid rival writer with a non-zero destination also reaches writeback that cycle; a zero destination on either side never collides.
- R9: A stall in any stage forces a stall in every younger stage (writeback, memory, execute, decode, fetch in that age order), except as R10 allows.
- R10: While execute holds a multiply or divide already in progress, execute ignores incoming stalls and does not check its operands, so stall_ex, fwd_a and fwd_b are all 0.
- R11: With execute not valid, no operand hazard is raised; with no valid store in memory, the store select is 0 and the memory stage raises no hazard of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pending_i | input | 2**REGW | Scoreboard: bit r set while register r has a write outstanding |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_mdu_busy_i | input | 1 | Execute instruction is a multiply/divide already in progress |
| ex_src_a_i | input | REGW | First source register of the execute instruction |
| ex_src_b_i | input | REGW | Second source register of the execute instruction |
| mem_valid_i | input | 1 | Memory stage holds an instruction |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_data_reg_i | input | REGW | Register supplying the store's data |
| slot_valid_i | input | NOLD | Older in-flight slot valid, index 0 nearest |
| slot_dest_i | input | NOLD*REGW | Packed slot destination registers |
| slot_ready_i | input | NOLD | Slot result available for bypass |
| slot_before_mem_i | input | NOLD | Slot is older than the memory-stage instruction |
| wb_valid_i | input | 1 | Writeback stage holds an instruction |
| wb_dest_i | input | REGW | Writeback destination register |
| rival_valid_i | input | NRIV | Older writer also at writeback this cycle |
| rival_dest_i | input | NRIV*REGW | Packed rival destination registers |
| fwd_a_o | output | SELW | Source A select: 0 register file, k slot k-1 |
| fwd_b_o | output | SELW | Source B select, same coding |
| fwd_st_o | output | SELW | Store data select, same coding |
| stall_if_o | output | 1 | Hold fetch |
| stall_id_o | output | 1 | Hold decode |
| stall_ex_o | output | 1 | Hold execute |
| stall_mem_o | output | 1 | Hold memory stage |
| stall_wb_o | output | 1 | Hold writeback |

## Verification
The bench targets duplicated destinations across slots. A search that ran oldest-first, or kept scanning after the first hit, would bypass stale data or stall behind a ready value. It also checks store data against slots that are younger than the store: a design that ignored the age flag would stall the store behind its own successors. Register 0, clear scoreboard bits and zero destinations at writeback are swept, since a missing guard there creates phantom stalls. The multicycle-busy case is combined with stalls from memory and writeback, which shows whether execute wrongly freezes or the younger stages fail to stall.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Pipeline stage positions inside the stall vector, youngest first.
  typedef enum int {
    STG_IF  = 0,
    STG_ID  = 1,
    STG_EX  = 2,
    STG_MEM = 3,
    STG_WB  = 4
  } stage_e;

  localparam int NSTAGE = 5;

  // Bypass select code for a slot index (0 is reserved for the register file).
  function automatic int slot_code(input int idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/hz_operand_search.sv
module hz_operand_search #(
  parameter int REGW = 5,
  parameter int NOLD = 4,
  parameter int SELW = 3
) (
  input  logic                 en_i,
  input  logic [2**REGW-1:0]   pending_i,
  input  logic [REGW-1:0]      src_i,
  input  logic [NOLD-1:0]      slot_valid_i,
  input  logic [NOLD*REGW-1:0] slot_dest_i,
  input  logic [NOLD-1:0]      slot_ready_i,
  input  logic [NOLD-1:0]      slot_mask_i,
  output logic                 hazard_o,
  output logic [SELW-1:0]      sel_o
);
  import hazard_pkg::*;

  // Event wires: a check is armed, and some slot matched.
  logic armed;
  logic any_hit;

  assign armed = en_i && (src_i != '0) && pending_i[src_i];

  always_comb begin
    logic hit;
    logic haz_n;
    logic [SELW-1:0] sel_n;
    hit   = 1'b0;
    haz_n = 1'b0;
    sel_n = '0;
    if (armed) begin
      for (int i = 0; i < NOLD; i++) begin
        if (!hit && slot_mask_i[i] && slot_valid_i[i] &&
            (slot_dest_i[i*REGW +: REGW] == src_i)) begin
          hit = 1'b1;
          if (slot_ready_i[i]) sel_n = SELW'(slot_code(i));
          else                 haz_n = 1'b1;
        end
      end
    end
    any_hit  = hit;
    hazard_o = haz_n;
    sel_o    = sel_n;

    AST_R0_QUIET: assert ((src_i != '0) || (!haz_n && sel_n == '0)); // R1
    AST_CLEAR_SB_QUIET: assert (pending_i[src_i] || (!haz_n && sel_n == '0)); // R2
    if (sel_n != '0) begin
      AST_FWD_FROM_READY: assert (slot_ready_i[int'(sel_n) - 1] &&
                                  slot_dest_i[(int'(sel_n) - 1)*REGW +: REGW] == src_i); // R4
    end
    AST_NO_HIT_RF: assert (hit || (!haz_n && sel_n == '0)); // R6
  end

endmodule

// File: rtl/hz_waw_check.sv
module hz_waw_check #(
  parameter int REGW = 5,
  parameter int NRIV = 2
) (
  input  logic                 wb_valid_i,
  input  logic [REGW-1:0]      wb_dest_i,
  input  logic [NRIV-1:0]      rival_valid_i,
  input  logic [NRIV*REGW-1:0] rival_dest_i,
  output logic                 collide_o
);

  logic [NRIV-1:0] rival_writes;

  generate
    for (genvar g = 0; g < NRIV; g++) begin : g_rival
      assign rival_writes[g] = rival_valid_i[g] &&
                               (rival_dest_i[g*REGW +: REGW] != '0);
    end
  endgenerate

  always_comb begin
    collide_o = wb_valid_i && (wb_dest_i != '0) && (|rival_writes);
    AST_WAW_ZERO_DEST: assert ((wb_dest_i != '0) || !collide_o); // R8
    AST_WAW_NEEDS_RIVAL: assert ((rival_writes != '0) || !collide_o); // R8
  end

endmodule

// File: rtl/hz_stall_chain.sv
module hz_stall_chain (
  input  logic                         ex_hazard_i,
  input  logic                         ex_mdu_busy_i,
  input  logic                         mem_hazard_i,
  input  logic                         wb_hazard_i,
  output logic [hazard_pkg::NSTAGE-1:0] stall_o
);
  import hazard_pkg::*;

  always_comb begin
    logic [NSTAGE-1:0] s;
    s          = '0;
    s[STG_WB]  = wb_hazard_i;
    s[STG_MEM] = mem_hazard_i || s[STG_WB];
    s[STG_EX]  = !ex_mdu_busy_i && (ex_hazard_i || s[STG_MEM]);
    s[STG_ID]  = s[STG_EX];
    s[STG_IF]  = s[STG_ID];
    stall_o    = s;

    AST_WB_TO_MEM: assert (!s[STG_WB] || s[STG_MEM]); // R9
    AST_MEM_TO_EX: assert (!s[STG_MEM] || s[STG_EX] || ex_mdu_busy_i); // R9
    AST_EX_TO_ID: assert (!s[STG_EX] || (s[STG_ID] && s[STG_IF])); // R9
    AST_MDU_RUNS: assert (!ex_mdu_busy_i || !s[STG_EX]); // R10
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REGW = 5,
  parameter int NOLD = 4,
  parameter int NRIV = 2,
  parameter int SELW = $clog2(NOLD + 1)
) (
  input  logic [2**REGW-1:0]   pending_i,
  input  logic                 ex_valid_i,
  input  logic                 ex_mdu_busy_i,
  input  logic [REGW-1:0]      ex_src_a_i,
  input  logic [REGW-1:0]      ex_src_b_i,
  input  logic                 mem_valid_i,
  input  logic                 mem_is_store_i,
  input  logic [REGW-1:0]      mem_data_reg_i,
  input  logic [NOLD-1:0]      slot_valid_i,
  input  logic [NOLD*REGW-1:0] slot_dest_i,
  input  logic [NOLD-1:0]      slot_ready_i,
  input  logic [NOLD-1:0]      slot_before_mem_i,
  input  logic                 wb_valid_i,
  input  logic [REGW-1:0]      wb_dest_i,
  input  logic [NRIV-1:0]      rival_valid_i,
  input  logic [NRIV*REGW-1:0] rival_dest_i,
  output logic [SELW-1:0]      fwd_a_o,
  output logic [SELW-1:0]      fwd_b_o,
  output logic [SELW-1:0]      fwd_st_o,
  output logic                 stall_if_o,
  output logic                 stall_id_o,
  output logic                 stall_ex_o,
  output logic                 stall_mem_o,
  output logic                 stall_wb_o
);
  import hazard_pkg::*;

  localparam int NOPND = 3;           // source A, source B, store data
  localparam int OP_A  = 0;
  localparam int OP_B  = 1;
  localparam int OP_ST = 2;

  // Named event wires for the assertions.
  logic                    ex_check_en;
  logic                    st_check_en;
  logic [NOPND-1:0]        opnd_en;
  logic [NOPND-1:0][REGW-1:0] opnd_src;
  logic [NOPND-1:0][NOLD-1:0] opnd_mask;
  logic [NOPND-1:0]        opnd_haz;
  logic [NOPND-1:0][SELW-1:0] opnd_sel;
  logic                    ex_hazard;
  logic                    waw_hit;
  logic [NSTAGE-1:0]       stall_vec;

  assign ex_check_en = ex_valid_i && !ex_mdu_busy_i;
  assign st_check_en = mem_valid_i && mem_is_store_i;

  assign opnd_en   = {st_check_en, ex_check_en, ex_check_en};
  assign opnd_src  = {mem_data_reg_i, ex_src_b_i, ex_src_a_i};
  assign opnd_mask = {slot_before_mem_i, {NOLD{1'b1}}, {NOLD{1'b1}}};

  generate
    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
      hz_operand_search #(
        .REGW (REGW),
        .NOLD (NOLD),
        .SELW (SELW)
      ) u_search (
        .en_i         (opnd_en[g]),
        .pending_i    (pending_i),
        .src_i        (opnd_src[g]),
        .slot_valid_i (slot_valid_i),
        .slot_dest_i  (slot_dest_i),
        .slot_ready_i (slot_ready_i),
        .slot_mask_i  (opnd_mask[g]),
        .hazard_o     (opnd_haz[g]),
        .sel_o        (opnd_sel[g])
      );
    end
  endgenerate

  assign ex_hazard = opnd_haz[OP_A] || opnd_haz[OP_B];

  hz_waw_check #(
    .REGW (REGW),
    .NRIV (NRIV)
  ) u_waw (
    .wb_valid_i    (wb_valid_i),
    .wb_dest_i     (wb_dest_i),
    .rival_valid_i (rival_valid_i),
    .rival_dest_i  (rival_dest_i),
    .collide_o     (waw_hit)
  );

  hz_stall_chain u_chain (
    .ex_hazard_i   (ex_hazard),
    .ex_mdu_busy_i (ex_mdu_busy_i),
    .mem_hazard_i  (opnd_haz[OP_ST]),
    .wb_hazard_i   (waw_hit),
    .stall_o       (stall_vec)
  );

  assign fwd_a_o     = opnd_sel[OP_A];
  assign fwd_b_o     = opnd_sel[OP_B];
  assign fwd_st_o    = opnd_sel[OP_ST];
  assign stall_if_o  = stall_vec[STG_IF];
  assign stall_id_o  = stall_vec[STG_ID];
  assign stall_ex_o  = stall_vec[STG_EX];
  assign stall_mem_o = stall_vec[STG_MEM];
  assign stall_wb_o  = stall_vec[STG_WB];

  always_comb begin
    AST_BUSY_NO_FWD: assert (!ex_mdu_busy_i ||
                             (opnd_sel[OP_A] == '0 && opnd_sel[OP_B] == '0)); // R10
    AST_NO_STORE_QUIET: assert (st_check_en ||
                                (opnd_sel[OP_ST] == '0 && !opnd_haz[OP_ST])); // R11
    AST_HAZ_NOT_FWD: assert (!(ex_hazard && !ex_mdu_busy_i) || stall_vec[STG_EX]); // R5
  end

endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  localparam int REGW = 5;
  localparam int NOLD = 4;
  localparam int NRIV = 2;
  localparam int SELW = 3;
  localparam int NREG = 2**REGW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [NREG-1:0]      pend;
  logic                 exv, busy, memv, st, wbv;
  logic [REGW-1:0]      sa, sb, sd, wbd;
  logic [NOLD-1:0]      sv, srdy, smask;
  logic [NOLD*REGW-1:0] sdst;
  logic [NRIV-1:0]      rv;
  logic [NRIV*REGW-1:0] rdst;
  logic [SELW-1:0]      fa, fb, fs;
  logic                 s_if, s_id, s_ex, s_mem, s_wb;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  hazard_unit #(.REGW(REGW), .NOLD(NOLD), .NRIV(NRIV), .SELW(SELW)) i_hazard_unit (
    .pending_i(pend), .ex_valid_i(exv), .ex_mdu_busy_i(busy),
    .ex_src_a_i(sa), .ex_src_b_i(sb), .mem_valid_i(memv), .mem_is_store_i(st),
    .mem_data_reg_i(sd), .slot_valid_i(sv), .slot_dest_i(sdst),
    .slot_ready_i(srdy), .slot_before_mem_i(smask), .wb_valid_i(wbv),
    .wb_dest_i(wbd), .rival_valid_i(rv), .rival_dest_i(rdst),
    .fwd_a_o(fa), .fwd_b_o(fb), .fwd_st_o(fs), .stall_if_o(s_if),
    .stall_id_o(s_id), .stall_ex_o(s_ex), .stall_mem_o(s_mem), .stall_wb_o(s_wb)
  );

  // Reference: scan oldest to nearest, the last hit (nearest) wins.
  task automatic ref_pick(input logic en, input logic [REGW-1:0] r,
                          input logic [NOLD-1:0] mk, output logic hz,
                          output logic [SELW-1:0] sel);
    int who;
    who = -1;
    for (int i = NOLD - 1; i >= 0; i--)
      if (mk[i] && sv[i] && sdst[i*REGW +: REGW] == r) who = i;
    hz = 1'b0;
    sel = '0;
    if (en && r != 0 && pend[r] && who >= 0) begin
      if (srdy[who]) sel = SELW'(who + 1);
      else hz = 1'b1;
    end
  endtask

  task automatic check(input string tag);
    logic ha, hb, hs, ew, em, ee;
    logic [SELW-1:0] ea, eb, es;
    logic [4:0] exp_st, got_st;
    #5;
    ref_pick(exv & ~busy, sa, {NOLD{1'b1}}, ha, ea);
    ref_pick(exv & ~busy, sb, {NOLD{1'b1}}, hb, eb);
    ref_pick(memv & st, sd, smask, hs, es);
    ew = 1'b0;
    for (int k = 0; k < NRIV; k++)
      if (wbv && wbd != 0 && rv[k] && rdst[k*REGW +: REGW] != 0) ew = 1'b1;
    em = hs | ew;
    ee = busy ? 1'b0 : (ha | hb | em);
    exp_st = {ew, em, ee, ee, ee};
    got_st = {s_wb, s_mem, s_ex, s_id, s_if};
    vectors++;
    if (fa !== ea || fb !== eb || fs !== es || got_st !== exp_st) begin
      fails++;
      $display("FAIL %s: fwd a/b/st=%0d/%0d/%0d stalls(wb,mem,ex,id,if)=%b expected %0d/%0d/%0d %b",
               tag, fa, fb, fs, got_st, ea, eb, es, exp_st);
    end
  endtask

  task automatic idle();
    pend = '0; exv = 0; busy = 0; sa = 0; sb = 0; memv = 0; st = 0; sd = 0;
    sv = '0; sdst = '0; srdy = '0; smask = '0; wbv = 0; wbd = 0; rv = '0; rdst = '0;
  endtask

  task automatic put_slot(input int i, input logic [REGW-1:0] d, input logic rdy,
                          input logic om);
    sv[i] = 1'b1; sdst[i*REGW +: REGW] = d; srdy[i] = rdy; smask[i] = om;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R11 reset state idle");
    rst_n = 1'b1;

    // R1: register 0 never hazards even with a not-ready slot writing 0
    @(negedge clk); idle(); pend = '1; exv = 1; put_slot(0, 0, 0, 1);
    memv = 1; st = 1; check("R1 reg0 source and store data");
    // R2: clear scoreboard bit suppresses the check
    @(negedge clk); idle(); exv = 1; sa = 3; put_slot(0, 3, 0, 1); check("R2 clear pending");
    // R3: nearest match decides, older not-ready ignored
    @(negedge clk); idle(); pend[3] = 1; exv = 1; sa = 3;
    put_slot(0, 3, 1, 1); put_slot(2, 3, 0, 1); check("R3 nearest ready wins");
    @(negedge clk); sv[0] = 0; check("R3 invalid slot skipped");
    // R4: ready match forwards from slot 3
    @(negedge clk); idle(); pend[7] = 1; exv = 1; sb = 7; put_slot(3, 7, 1, 1);
    check("R4 forward slot 3");
    // R5: not-ready match stalls execute and younger
    @(negedge clk); idle(); pend[5] = 1; exv = 1; sa = 5; put_slot(1, 5, 0, 1);
    check("R5 not ready stalls");
    // R6: pending, no matching slot
    @(negedge clk); idle(); pend[9] = 1; exv = 1; sa = 9; put_slot(0, 8, 0, 1);
    check("R6 register file");
    // R7: store data ignores younger slot, forwards from older
    @(negedge clk); idle(); pend[4] = 1; memv = 1; st = 1; sd = 4;
    put_slot(0, 4, 0, 0); put_slot(1, 4, 1, 1); check("R7 store younger masked");
    @(negedge clk); smask[0] = 1; check("R7 store data stall");
    // R8: writeback collision and zero-destination cases
    @(negedge clk); idle(); wbv = 1; wbd = 6; rv[1] = 1; rdst[1*REGW +: REGW] = 2;
    check("R8 WAW collision");
    @(negedge clk); wbd = 0; check("R8 zero dest no collide");
    @(negedge clk); wbd = 6; rdst[1*REGW +: REGW] = 0; check("R8 zero rival no collide");
    // R9 / R10: stall ripple versus busy multicycle execute
    @(negedge clk); idle(); wbv = 1; wbd = 1; rv = 2'b01; rdst[4:0] = 1; exv = 1;
    check("R9 wb stall ripples");
    @(negedge clk); busy = 1; pend = '1; sa = 2; put_slot(0, 2, 1, 1);
    check("R10 busy ignores stall and operands");
    // R11: execute invalid
    @(negedge clk); idle(); pend = '1; sa = 2; sb = 2; put_slot(0, 2, 0, 1);
    check("R11 execute invalid");

    // Sweep: small register range so matches are frequent
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      pend = '0;
      for (int r = 0; r < 4; r++) pend[r] = 1'($urandom);
      exv = 1'($urandom); busy = ($urandom % 5) == 0;
      sa = REGW'($urandom % 4); sb = REGW'($urandom % 4); sd = REGW'($urandom % 4);
      memv = 1'($urandom); st = 1'($urandom);
      sv = NOLD'($urandom); srdy = NOLD'($urandom); smask = NOLD'($urandom);
      for (int i = 0; i < NOLD; i++) sdst[i*REGW +: REGW] = REGW'($urandom % 4);
      wbv = 1'($urandom); wbd = REGW'($urandom % 3);
      rv = NRIV'($urandom);
      for (int k = 0; k < NRIV; k++) rdst[k*REGW +: REGW] = REGW'($urandom % 3);
      check("R3 R4 R5 R7 R8 R9 R10 sweep");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule